// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a flat physical address. A logical address has two parts: a segment number and an offset inside that segment. The segment number selects one entry of a small segment table held on chip. Each entry holds a base address, a limit (the length of the segment), a valid flag and three permission flags, one each for read, write and execute. A separate segment-count register says how many segments the current program may use.

Software loads the table one entry at a time through a simple write port. It writes the count register through its own write strobe. Each translation request carries an access type. One clock later the block returns one of two results. On success it returns the relocated address, which is the entry base plus the offset. On failure it returns a fault flag with a cause code that a trap handler outside this block can act on.

Top module: `seg_xlat`

## Requirements
- R1: Reset (synchronous, active low) clears the response outputs, sets the segment count to zero and marks every table entry invalid. A request made right after reset therefore faults with cause 1, and once the count is raised it faults with cause 2 until entries are loaded.
- R2: A request presented with `req_valid` high at a rising edge shows its result on the outputs after that edge, with `rsp_valid` high. When no request was presented at the previous edge, `rsp_valid`, `rsp_fault`, `rsp_cause` and `rsp_paddr` are all zero.
- R3: A segment number greater than or equal to the segment count faults with cause code 1.
- R4: An in-range segment whose entry has its valid flag at 0 faults with cause code 2.
- R5: An offset greater than or equal to the entry limit faults with cause code 3. The limit is OFF_W+1 bits wide. A limit of 0 rejects every offset, and a limit of 2^OFF_W admits every offset.
- R6: Access types are encoded 0 = read, 1 = write, 2 = execute and 3 = reserved. The permission field has bit 0 = read, bit 1 = write and bit 2 = execute. An access whose permission bit is clear, or any reserved access, faults with cause code 4.
- R7: When several checks fail, the cause reported is the first failing check in this order: range (1), then valid (2), then limit (3), then permission (4).
- R8: A request that passes every check returns cause 0, fault low and a physical address equal to (base + offset) modulo 2^PADDR_W.
- R9: A faulting response has `rsp_fault` high, a nonzero cause and a physical address of zero. A successful response has cause 0.
- R10: A request presented in the same cycle as an entry write or a count write sees the old contents. A request presented one cycle later or after that sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_we | input | 1 | Write strobe for one table entry |
| tbl_idx | input | SEG_W | Index of the entry to write |
| tbl_base | input | PADDR_W | Base address to store |
| tbl_limit | input | OFF_W+1 | Segment length to store |
| tbl_valid | input | 1 | Valid flag to store |
| tbl_perm | input | 3 | Permission flags to store (bit 0 read, bit 1 write, bit 2 execute) |
| cnt_we | input | 1 | Write strobe for the segment-count register |
| cnt_val | input | SEG_W+1 | New segment count |
| req_valid | input | 1 | Translation request present |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset of the request |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | PADDR_W | Physical address; zero on a fault |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 3 | Fault cause (0 none, 1 range, 2 invalid, 3 limit, 4 permission) |

## Verification
The bench builds the unit with SEG_W=2, OFF_W=4 and PADDR_W=6. With these values a full sweep of every segment, every offset and every access type costs only 256 requests. The sweep is repeated for each segment count from 0 to 4 and for two different table layouts. At this size the exhaustive run reaches the corner cases directly: a limit of 0, a limit of 16 that spans the whole offset range, bases that wrap past 2^6, and entries where several checks fail at once. Directed sequences then cover a table or count write in the same cycle as a request, and the idle cycles between requests.

// File: rtl/seg_xlat_pkg.sv
// Shared encodings for the segmented address translation unit.
// Assumes every user compares cause and access codes through these names.
package seg_xlat_pkg;

    // Fault cause; the numeric order is also the check priority.
    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_RANGE   = 3'd1,
        CAUSE_INVALID = 3'd2,
        CAUSE_LIMIT   = 3'd3,
        CAUSE_PERM    = 3'd4
    } cause_e;

    // Access type carried with each request.
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    // Bit positions inside the three-bit permission field.
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;
    localparam int PERM_W  = 3;

endpackage

// File: rtl/seg_xlat_table.sv
// Segment table plus segment-count register.
// Writes land on the clock edge; reads are combinational from the stored
// state, so a request sees a write only from the next cycle on.
// Assumes wr_idx is always below 2^SEG_W (it is, by width).
module seg_xlat_table #(
    parameter int SEG_W   = 3,
    parameter int OFF_W   = 12,
    parameter int PADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEG_W-1:0]   wr_idx,
    input  logic [PADDR_W-1:0] wr_base,
    input  logic [OFF_W:0]     wr_limit,
    input  logic               wr_valid,
    input  logic [seg_xlat_pkg::PERM_W-1:0] wr_perm,
    input  logic               cnt_wr_en,
    input  logic [SEG_W:0]     cnt_wr_val,
    input  logic [SEG_W-1:0]   rd_idx,
    output logic [PADDR_W-1:0] rd_base,
    output logic [OFF_W:0]     rd_limit,
    output logic               rd_valid,
    output logic [seg_xlat_pkg::PERM_W-1:0] rd_perm,
    output logic [SEG_W:0]     seg_count
);
    localparam int NUM_SEGS = 1 << SEG_W;
    localparam int PW       = seg_xlat_pkg::PERM_W;

    logic [PADDR_W-1:0] base_q  [NUM_SEGS];
    logic [OFF_W:0]     limit_q [NUM_SEGS];
    logic [PW-1:0]      perm_q  [NUM_SEGS];
    logic [NUM_SEGS-1:0] valid_q;
    logic [NUM_SEGS-1:0] hit;
    logic [SEG_W:0]     cnt_q;

    // One write-select line per entry.
    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_sel
        assign hit[g] = wr_en && (wr_idx == SEG_W'(g));
    end

    // Store the selected entry; reset invalidates every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NUM_SEGS; i++) begin
                base_q[i]  <= '0;
                limit_q[i] <= '0;
                perm_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SEGS; i++) begin
                if (hit[i]) begin
                    base_q[i]  <= wr_base;
                    limit_q[i] <= wr_limit;
                    perm_q[i]  <= wr_perm;
                    valid_q[i] <= wr_valid;
                end
            end
        end
    end

    // Segment-count register, zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_wr_en) cnt_q <= cnt_wr_val;
    end

    // Read port for the requested segment.
    always_comb begin
        rd_base  = base_q[rd_idx];
        rd_limit = limit_q[rd_idx];
        rd_perm  = perm_q[rd_idx];
        rd_valid = valid_q[rd_idx];
    end

    assign seg_count = cnt_q;
endmodule

// File: rtl/seg_xlat_check.sv
// Legality and permission checks for one request, purely combinational.
// Reports the first failing check in the order range, valid, limit,
// permission. Assumes the entry inputs belong to the requested segment.
module seg_xlat_check #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  seg_xlat_pkg::access_e acc,
    input  logic [SEG_W:0]   seg_count,
    input  logic             ent_valid,
    input  logic [OFF_W:0]   ent_limit,
    input  logic [seg_xlat_pkg::PERM_W-1:0] ent_perm,
    output seg_xlat_pkg::cause_e cause,
    output logic             fault
);
    import seg_xlat_pkg::*;

    logic out_of_range;
    logic over_limit;
    logic allowed;

    // Segment number against the count, offset against the limit.
    always_comb begin
        out_of_range = {1'b0, seg} >= seg_count;
        over_limit   = {1'b0, off} >= ent_limit;
    end

    // Map the access type to its permission bit; reserved is never allowed.
    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = ent_perm[PERM_RD];
            ACC_WRITE: allowed = ent_perm[PERM_WR];
            ACC_EXEC:  allowed = ent_perm[PERM_EX];
            default:   allowed = 1'b0;
        endcase
    end

    // Priority encoder of the failing checks.
    always_comb begin
        if (out_of_range)    cause = CAUSE_RANGE;
        else if (!ent_valid) cause = CAUSE_INVALID;
        else if (over_limit) cause = CAUSE_LIMIT;
        else if (!allowed)   cause = CAUSE_PERM;
        else                 cause = CAUSE_NONE;
        fault = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/seg_xlat_relocate.sv
// Adds the segment base to the offset. The sum wraps modulo 2^PADDR_W.
// Assumes the offset is not wider than the physical address, and
// truncates it when it is.
module seg_xlat_relocate #(
    parameter int OFF_W   = 12,
    parameter int PADDR_W = 16
) (
    input  logic [PADDR_W-1:0] base,
    input  logic [OFF_W-1:0]   off,
    output logic [PADDR_W-1:0] paddr
);
    logic [PADDR_W-1:0] off_ext;

    // Bring the offset to the physical address width.
    if (PADDR_W >= OFF_W) begin : g_zext
        assign off_ext = PADDR_W'(off);
    end else begin : g_trunc
        assign off_ext = off[PADDR_W-1:0];
    end

    // Plain modular addition.
    assign paddr = base + off_ext;
endmodule

// File: rtl/seg_xlat.sv
// Top of the segmented address translation unit. It looks up the segment
// table, runs the checks, relocates the offset and registers the result,
// which appears one clock after the request. Assumes requests and table
// writes are synchronous to clk.
module seg_xlat #(
    parameter int SEG_W   = 3,
    parameter int OFF_W   = 12,
    parameter int PADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [SEG_W-1:0]   tbl_idx,
    input  logic [PADDR_W-1:0] tbl_base,
    input  logic [OFF_W:0]     tbl_limit,
    input  logic               tbl_valid,
    input  logic [2:0]         tbl_perm,
    input  logic               cnt_we,
    input  logic [SEG_W:0]     cnt_val,
    input  logic               req_valid,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    output logic [PADDR_W-1:0] rsp_paddr,
    output logic               rsp_fault,
    output logic [2:0]         rsp_cause
);
    import seg_xlat_pkg::*;

    logic [PADDR_W-1:0] ent_base;
    logic [OFF_W:0]     ent_limit;
    logic               ent_valid;
    logic [PERM_W-1:0]  ent_perm;
    logic [SEG_W:0]     seg_count;
    cause_e             chk_cause;
    logic               chk_fault;
    logic [PADDR_W-1:0] sum_addr;

    seg_xlat_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PADDR_W(PADDR_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_base(tbl_base),
        .wr_limit(tbl_limit), .wr_valid(tbl_valid), .wr_perm(tbl_perm),
        .cnt_wr_en(cnt_we), .cnt_wr_val(cnt_val),
        .rd_idx(req_seg), .rd_base(ent_base), .rd_limit(ent_limit),
        .rd_valid(ent_valid), .rd_perm(ent_perm), .seg_count(seg_count)
    );

    seg_xlat_check #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_check (
        .seg(req_seg), .off(req_off), .acc(access_e'(req_acc)),
        .seg_count(seg_count), .ent_valid(ent_valid),
        .ent_limit(ent_limit), .ent_perm(ent_perm),
        .cause(chk_cause), .fault(chk_fault)
    );

    seg_xlat_relocate #(.OFF_W(OFF_W), .PADDR_W(PADDR_W)) u_reloc (
        .base(ent_base), .off(req_off), .paddr(sum_addr)
    );

    // Register the result; idle cycles and faults drive a zero address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= 3'd0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && chk_fault;
            rsp_cause <= req_valid ? 3'(chk_cause) : 3'd0;
            rsp_paddr <= (req_valid && !chk_fault) ? sum_addr : '0;
        end
    end
endmodule

// File: rtl/seg_xlat_props.sv
// Temporal properties of the translation unit, attached through bind.
// Assumes seg_count is the stored count that the table module drives.
module seg_xlat_props #(
    parameter int SEG_W   = 3,
    parameter int PADDR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [SEG_W-1:0]   req_seg,
    input logic [SEG_W:0]     seg_count,
    input logic               rsp_valid,
    input logic [PADDR_W-1:0] rsp_paddr,
    input logic               rsp_fault,
    input logic [2:0]         rsp_cause
);
    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_cause == 3'd0 && rsp_paddr == '0));

    assert_range_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= seg_count)) |=> (rsp_fault && rsp_cause == 3'd1));

    assert_cause_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cause <= 3'd4);

    assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0 && rsp_cause != 3'd0 && rsp_valid));

    assert_success_no_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_cause == 3'd0);
endmodule

bind seg_xlat seg_xlat_props #(.SEG_W(SEG_W), .PADDR_W(PADDR_W)) u_props (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
    .seg_count(seg_count), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
);

// File: tb/seg_xlat_test.sv
`timescale 1ns/1ps
module seg_xlat_test;
    localparam int SW = 2;
    localparam int OW = 4;
    localparam int PW = 6;
    localparam int NS = 1 << SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_we = 1'b0;
    logic [SW-1:0] tbl_idx = '0;
    logic [PW-1:0] tbl_base = '0;
    logic [OW:0] tbl_limit = '0;
    logic tbl_valid = 1'b0;
    logic [2:0] tbl_perm = '0;
    logic cnt_we = 1'b0;
    logic [SW:0] cnt_val = '0;
    logic req_valid = 1'b0;
    logic [SW-1:0] req_seg = '0;
    logic [OW-1:0] req_off = '0;
    logic [1:0] req_acc = '0;
    logic rsp_valid;
    logic [PW-1:0] rsp_paddr;
    logic rsp_fault;
    logic [2:0] rsp_cause;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Requirement model of the table.
    int m_base [NS];
    int m_limit[NS];
    int m_valid[NS];
    int m_perm [NS];
    int m_cnt;

    seg_xlat #(.SEG_W(SW), .OFF_W(OW), .PADDR_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_base(tbl_base), .tbl_limit(tbl_limit), .tbl_valid(tbl_valid),
        .tbl_perm(tbl_perm), .cnt_we(cnt_we), .cnt_val(cnt_val),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_cause(input int s, input int o, input int a);
        if (s >= m_cnt) return 1;
        if (m_valid[s] == 0) return 2;
        if (o >= m_limit[s]) return 3;
        if (a == 3 || ((m_perm[s] >> a) & 1) == 0) return 4;
        return 0;
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Called at a falling edge; leaves the request driven for one rising edge.
    task automatic put_req(input int s, input int o, input int a);
        req_valid = 1'b1;
        req_seg = SW'(s);
        req_off = OW'(o);
        req_acc = 2'(a);
    endtask

    // Compare the registered response with the model result.
    task automatic cmp_rsp(input int c, input int pa, input string tag);
        int got;
        int want;
        got  = {rsp_valid, rsp_fault, rsp_cause, rsp_paddr};
        want = {1'b1, (c != 0), 3'(c), PW'(pa)};
        check(got == want, tag, "valid/fault/cause/paddr packed", got, want);
    endtask

    task automatic do_req(input int s, input int o, input int a, input string tag);
        int c;
        int pa;
        c  = exp_cause(s, o, a);
        pa = (c == 0) ? ((m_base[s] + o) % (1 << PW)) : 0;
        put_req(s, o, a);
        @(negedge clk);
        req_valid = 1'b0;
        cmp_rsp(c, pa, (tag == "") ? tag_of(c) : tag);
    endtask

    task automatic wr_ent(input int i, input int b, input int l, input int v, input int p);
        tbl_we = 1'b1; tbl_idx = SW'(i); tbl_base = PW'(b);
        tbl_limit = (OW+1)'(l); tbl_valid = v[0]; tbl_perm = 3'(p);
        @(negedge clk);
        tbl_we = 1'b0;
        m_base[i] = b; m_limit[i] = l; m_valid[i] = v; m_perm[i] = p;
    endtask

    task automatic wr_cnt(input int n);
        cnt_we = 1'b1; cnt_val = (SW+1)'(n);
        @(negedge clk);
        cnt_we = 1'b0;
        m_cnt = n;
    endtask

    task automatic sweep();
        for (int s = 0; s < NS; s++)
            for (int o = 0; o < (1 << OW); o++)
                for (int a = 0; a < 4; a++)
                    do_req(s, o, a, "");
    endtask

    initial begin
        int c;
        for (int i = 0; i < NS; i++) begin
            m_base[i] = 0; m_limit[i] = 0; m_valid[i] = 0; m_perm[i] = 0;
        end
        m_cnt = 0;
        repeat (3) @(negedge clk);
        // R1: response outputs cleared while and after reset.
        check(rsp_valid == 0 && rsp_fault == 0 && rsp_cause == 0 && rsp_paddr == 0,
              "R1", "outputs during reset", rsp_valid, 0);
        rsp_n_release: rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
        // R1: count is zero, so every segment is out of range.
        do_req(0, 0, 0, "R1");
        do_req(3, 5, 2, "R1");
        // R1: entries invalid after reset.
        wr_cnt(4);
        do_req(0, 0, 0, "R1");
        do_req(2, 1, 1, "R1");

        // Layout A: full span, read-only, wrapping base, zero limit.
        wr_ent(0, 0, 16, 1, 7);
        wr_ent(1, 20, 5, 1, 1);
        wr_ent(2, 60, 10, 1, 6);
        wr_ent(3, 33, 0, 1, 2);
        for (int n = 0; n <= NS; n++) begin
            wr_cnt(n);
            sweep();
        end

        // R2: idle cycle after a request returns quiet outputs.
        do_req(0, 3, 0, "R8");
        @(negedge clk);
        check({rsp_valid, rsp_fault, rsp_cause, rsp_paddr} == 0, "R2",
              "idle outputs", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, 0);
        // R2: back-to-back requests keep rsp_valid high.
        put_req(0, 1, 0);
        @(negedge clk);
        check(rsp_valid == 1, "R2", "first of pair valid", rsp_valid, 1);
        put_req(1, 2, 0);
        @(negedge clk);
        req_valid = 1'b0;
        cmp_rsp(0, 22, "R2");

        // Layout B: invalid entries and mixed failures; count 3.
        wr_ent(0, 8, 8, 1, 0);
        wr_ent(1, 40, 2, 0, 7);
        wr_ent(3, 50, 16, 0, 4);
        wr_cnt(3);
        sweep();
        // R7: out of range beats invalid (seg 3 invalid and >= count).
        do_req(3, 0, 0, "R7");
        // R7: invalid beats over-limit (seg 1 invalid, offset 9 >= 2).
        do_req(1, 9, 0, "R7");
        // R7: over-limit beats permission (seg 0 has no permission).
        do_req(0, 12, 1, "R7");
        c = exp_cause(0, 12, 1);
        check(c == 3, "R7", "model priority", c, 3);

        // R10: entry write and request in the same cycle see old contents.
        tbl_we = 1'b1; tbl_idx = 2'd2; tbl_base = 6'd5;
        tbl_limit = 5'd16; tbl_valid = 1'b1; tbl_perm = 3'd1;
        put_req(2, 3, 0);
        c = exp_cause(2, 3, 0);
        @(negedge clk);
        tbl_we = 1'b0; req_valid = 1'b0;
        cmp_rsp(c, 0, "R10");
        m_base[2] = 5; m_limit[2] = 16; m_valid[2] = 1; m_perm[2] = 1;
        do_req(2, 3, 0, "R10");
        // R10: count write in the same cycle as a request.
        cnt_we = 1'b1; cnt_val = 3'd4;
        wr_ent_dummy: put_req(3, 0, 2);
        @(negedge clk);
        cnt_we = 1'b0; req_valid = 1'b0;
        cmp_rsp(1, 0, "R10");
        m_cnt = 4;
        do_req(3, 0, 2, "R10");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule